// File: doc/BRIEF.md
# Prioritized trace message queue

This block gathers debug trace messages from four producers (watchpoint, ownership, branch and data trace) into one first-in first-out queue. The queue feeds an auxiliary trace port through a valid/ready handshake. Each producer offers a message as a valid strobe plus a fixed-width payload. When several producers fire in one cycle, a fixed priority picks which messages are kept. At most two messages enter per cycle, and a data-trace message only enters when it is the sole offer.

If an offer does not fit, the queue goes into a drain mode. In that mode it refuses every new message until the stored entries have all been read out. It then inserts a single error entry whose code is a mask of the producer types that were refused. Two strobes go to a neighbouring data-trace sync controller. One marks a data-trace message that was not queued. The other marks the cycle in which the error entry is inserted, so that the controller can force a synchronizing message next.

Top module: `trace_msg_queue`

## Requirements
- R1: A synchronous active-high reset empties the queue and leaves drain mode, so `out_valid` is low after it, and no error entry follows it.
- R2: Entries leave on `out_*` in exactly the order they were queued. An entry is popped when `out_valid` and `out_ready` are both high at a clock edge.
- R3: Among watchpoint, ownership and branch, the two highest-priority offers in a cycle are queued in the order watchpoint, ownership, branch, and a third offer is dropped. `out_src` is 3 for watchpoint, 2 for ownership, 1 for branch and 0 for data trace.
- R4: A data-trace offer is queued only when no other producer offers in the same cycle. Otherwise it is dropped, and `dt_lost` is high in that same cycle.
- R5: `dt_lost` is high in every cycle in which `dt_valid` is high and the data-trace message is not queued, including during drain and in an overrun cycle. It is low otherwise.
- R6: An overrun occurs in a cycle when the number of messages picked by R3/R4 exceeds `DEPTH` minus the stored count before any pop. None of that cycle's messages is queued, and drain mode begins. Every offer is discarded while in drain mode.
- R7: Drain mode ends in the first cycle in which the queue holds nothing. In that cycle exactly one error entry is queued, with `out_err`=1, `out_src`=0, and `out_data[3:0]` a mask (bit 3 watchpoint, bit 2 ownership, bit 1 branch, bit 0 data trace). The mask covers the messages picked in the overrun cycle and every type offered during drain, including the ending cycle. The upper payload bits are zero.
- R8: `ovr_recovered` is a one-cycle pulse high exactly in the cycle the error entry is queued. `out_valid` is low in that cycle.
- R9: While `out_valid` is high and `out_ready` is low, `out_src`, `out_err` and `out_data` hold their values.
- R10: The queue holds `DEPTH` entries (default 32). Filling it to exactly `DEPTH` causes no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wp_valid | input | 1 | Watchpoint message offered |
| wp_data | input | PW | Watchpoint payload |
| ot_valid | input | 1 | Ownership message offered |
| ot_data | input | PW | Ownership payload |
| bt_valid | input | 1 | Branch message offered |
| bt_data | input | PW | Branch payload |
| dt_valid | input | 1 | Data-trace message offered |
| dt_data | input | PW | Data-trace payload |
| out_valid | output | 1 | Head entry present |
| out_ready | input | 1 | Trace port takes the head entry |
| out_src | output | 2 | Producer code of the head entry |
| out_err | output | 1 | Head entry is an error entry |
| out_data | output | PW | Head payload, or the refusal mask for an error entry |
| dt_lost | output | 1 | A data-trace offer was not queued this cycle |
| ovr_recovered | output | 1 | Error entry inserted this cycle |

## Verification
The error insertion that ends a drain can fall in the same cycle as fresh offers. Those offers must be refused and must still widen the mask being written. A pop and a two-message write can also meet at a nearly full queue, where the free-space test ignores the pop. Both cases are provoked by sweeping all sixteen valid patterns against varying ready patterns on a four-entry queue, with directed fill-to-overrun runs. They are judged cycle by cycle against a queue model in the bench that applies the pick, overrun and mask rules arithmetically.

// File: rtl/trq_pkg.sv
package trq_pkg;
  localparam int NSRC = 4;
  localparam int SRCW = 2;
  localparam int MASKW = NSRC;
  localparam logic [SRCW-1:0] SRC_WP = 2'd3;
  localparam logic [SRCW-1:0] SRC_OT = 2'd2;
  localparam logic [SRCW-1:0] SRC_BT = 2'd1;
  localparam logic [SRCW-1:0] SRC_DT = 2'd0;
endpackage

// File: rtl/trq_arbiter.sv
module trq_arbiter
  import trq_pkg::*;
(
  input  logic [NSRC-1:0] offer,
  output logic            s0_v,
  output logic [SRCW-1:0] s0_src,
  output logic            s1_v,
  output logic [SRCW-1:0] s1_src
);
  always_comb begin
    s0_v   = 1'b0;
    s0_src = SRC_DT;
    s1_v   = 1'b0;
    s1_src = SRC_DT;
    if (|offer[NSRC-1:1]) begin
      for (int i = NSRC - 1; i >= 1; i--) begin
        if (offer[i]) begin
          if (!s0_v) begin
            s0_v   = 1'b1;
            s0_src = SRCW'(i);
          end else if (!s1_v) begin
            s1_v   = 1'b1;
            s1_src = SRCW'(i);
          end
        end
      end
    end else if (offer[0]) begin
      s0_v   = 1'b1;
      s0_src = SRC_DT;
    end
  end
endmodule

// File: rtl/trq_store.sv
module trq_store #(
  parameter int DEPTH = 32,
  parameter int EW    = 11,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr0_en,
  input  logic [EW-1:0] wr0_d,
  input  logic          wr1_en,
  input  logic [EW-1:0] wr1_d,
  input  logic          rd_en,
  output logic [EW-1:0] head,
  output logic [CW-1:0] count
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW-1:0] wr_ptr_nx;
  logic [CW-1:0] n_wr;

  assign wr_ptr_nx = wr_ptr + AW'(1);
  assign n_wr      = CW'(wr0_en) + CW'(wr1_en);
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr0_en) mem[wr_ptr] <= wr0_d;
    if (wr1_en) mem[wr_ptr_nx] <= wr1_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(n_wr);
      if (rd_en) rd_ptr <= rd_ptr + AW'(1);
      count <= count + n_wr - CW'(rd_en);
    end
  end
endmodule

// File: rtl/trq_overrun.sv
module trq_overrun
  import trq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic [MASKW-1:0] trig_mask,
  input  logic [MASKW-1:0] offer,
  input  logic             empty,
  output logic             draining,
  output logic             ins_err,
  output logic [MASKW-1:0] err_mask
);
  logic [MASKW-1:0] mask_q;

  assign ins_err  = draining && empty;
  assign err_mask = mask_q | offer;

  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      mask_q   <= '0;
    end else if (draining) begin
      if (empty) begin
        draining <= 1'b0;
        mask_q   <= '0;
      end else begin
        mask_q <= mask_q | offer;
      end
    end else if (trig) begin
      draining <= 1'b1;
      mask_q   <= trig_mask;
    end
  end
endmodule

// File: rtl/trace_msg_queue.sv
module trace_msg_queue
  import trq_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PW    = 8,
  localparam int EW   = PW + SRCW + 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wp_valid,
  input  logic [PW-1:0]   wp_data,
  input  logic            ot_valid,
  input  logic [PW-1:0]   ot_data,
  input  logic            bt_valid,
  input  logic [PW-1:0]   bt_data,
  input  logic            dt_valid,
  input  logic [PW-1:0]   dt_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [SRCW-1:0] out_src,
  output logic            out_err,
  output logic [PW-1:0]   out_data,
  output logic            dt_lost,
  output logic            ovr_recovered
);
  logic [NSRC-1:0]  offer;
  logic [PW-1:0]    pay [NSRC];
  logic             s0_v, s1_v;
  logic [SRCW-1:0]  s0_src, s1_src;
  logic [CW-1:0]    count;
  logic [CW:0]      free_slots, n_req;
  logic             trig, accept, draining, ins_err;
  logic [MASKW-1:0] pick_mask, err_mask;
  logic [PW-1:0]    err_data;
  logic             wr0_en, wr1_en, rd_en;
  logic [EW-1:0]    wr0_d, wr1_d, head;

  assign offer = {wp_valid, ot_valid, bt_valid, dt_valid};
  assign pay[SRC_WP] = wp_data;
  assign pay[SRC_OT] = ot_data;
  assign pay[SRC_BT] = bt_data;
  assign pay[SRC_DT] = dt_data;

  trq_arbiter u_arb (
    .offer (offer),
    .s0_v  (s0_v),
    .s0_src(s0_src),
    .s1_v  (s1_v),
    .s1_src(s1_src)
  );

  assign n_req      = (CW + 1)'(s0_v) + (CW + 1)'(s1_v);
  assign free_slots = (CW + 1)'(DEPTH) - (CW + 1)'(count);
  assign trig       = !draining && (n_req > free_slots);
  assign accept     = !draining && !trig;

  always_comb begin
    pick_mask = '0;
    if (s0_v) pick_mask[s0_src] = 1'b1;
    if (s1_v) pick_mask[s1_src] = 1'b1;
  end

  trq_overrun u_ovr (
    .clk      (clk),
    .rst      (rst),
    .trig     (trig),
    .trig_mask(pick_mask),
    .offer    (offer),
    .empty    (count == '0),
    .draining (draining),
    .ins_err  (ins_err),
    .err_mask (err_mask)
  );

  always_comb begin
    err_data = '0;
    err_data[MASKW-1:0] = err_mask;
  end

  always_comb begin
    wr0_en = 1'b0;
    wr1_en = 1'b0;
    wr0_d  = {1'b0, s0_src, pay[s0_src]};
    wr1_d  = {1'b0, s1_src, pay[s1_src]};
    if (ins_err) begin
      wr0_en = 1'b1;
      wr0_d  = {1'b1, SRC_DT, err_data};
    end else if (accept) begin
      wr0_en = s0_v;
      wr1_en = s1_v;
    end
  end

  assign out_valid = (count != '0);
  assign rd_en     = out_valid && out_ready;

  trq_store #(.DEPTH(DEPTH), .EW(EW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .wr0_en(wr0_en),
    .wr0_d (wr0_d),
    .wr1_en(wr1_en),
    .wr1_d (wr1_d),
    .rd_en (rd_en),
    .head  (head),
    .count (count)
  );

  assign out_err  = head[EW-1];
  assign out_src  = head[PW +: SRCW];
  assign out_data = head[PW-1:0];

  assign dt_lost       = dt_valid && !(accept && s0_v && s0_src == SRC_DT);
  assign ovr_recovered = ins_err;
endmodule

// File: rtl/trq_checker.sv
module trq_checker #(
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          wp_valid,
  input logic          ot_valid,
  input logic          bt_valid,
  input logic          dt_valid,
  input logic          out_valid,
  input logic          out_ready,
  input logic [1:0]    out_src,
  input logic          out_err,
  input logic [PW-1:0] out_data,
  input logic          dt_lost,
  input logic          ovr_recovered
);
  // R1
  reset_empty_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  // R9
  head_stable_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_src) && $stable(out_err) && $stable(out_data));

  // R8
  recover_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_recovered |-> !out_valid);

  // R7
  err_follows_chk: assert property (@(posedge clk) disable iff (rst)
    ovr_recovered |=> out_valid && out_err && out_src == 2'd0 && out_data[3:0] != 4'd0);

  // R4
  dt_collide_chk: assert property (@(posedge clk) disable iff (rst)
    dt_valid && (wp_valid || ot_valid || bt_valid) |-> dt_lost);

  // R5
  dt_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !dt_valid |-> !dt_lost);
endmodule

bind trace_msg_queue trq_checker #(.PW(PW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .wp_valid     (wp_valid),
  .ot_valid     (ot_valid),
  .bt_valid     (bt_valid),
  .dt_valid     (dt_valid),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_src      (out_src),
  .out_err      (out_err),
  .out_data     (out_data),
  .dt_lost      (dt_lost),
  .ovr_recovered(ovr_recovered)
);

// File: tb/trace_msg_queue_tb.sv
module trace_msg_queue_tb;
  localparam int DEPTH = 4;
  localparam int PW    = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wp_valid = 0, ot_valid = 0, bt_valid = 0, dt_valid = 0;
  logic [PW-1:0] wp_data = 0, ot_data = 0, bt_data = 0, dt_data = 0;
  logic out_ready = 0;
  logic out_valid, out_err, dt_lost, ovr_recovered;
  logic [1:0] out_src;
  logic [PW-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [PW+2:0] mq [$];
  bit            m_drain = 0;
  logic [3:0]    m_mask  = 0;

  always #5 clk = ~clk;

  trace_msg_queue #(.DEPTH(DEPTH), .PW(PW)) u_dut (
    .clk(clk), .rst(rst),
    .wp_valid(wp_valid), .wp_data(wp_data),
    .ot_valid(ot_valid), .ot_data(ot_data),
    .bt_valid(bt_valid), .bt_data(bt_data),
    .dt_valid(dt_valid), .dt_data(dt_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_err(out_err), .out_data(out_data),
    .dt_lost(dt_lost), .ovr_recovered(ovr_recovered)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_head(input string tag);
    check({tag, " R2 R3 R6 out_valid"}, 32'(out_valid), 32'(mq.size() != 0));
    if (mq.size() != 0)
      check({tag, " R2 R3 R7 head"}, 32'({out_err, out_src, out_data}), 32'(mq[0]));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    wp_valid = 1; dt_valid = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    wp_valid = 0; dt_valid = 0;
    mq.delete();
    m_drain = 0;
    m_mask  = 0;
    check("R1 out_valid after reset", 32'(out_valid), 32'd0);
  endtask

  // one cycle: offer v = {wp,ot,bt,dt}, ready r
  task automatic step(input logic [3:0] v, input bit r, input string tag);
    logic [PW-1:0] d [4];
    logic [PW+2:0] pushes [$];
    int picks [$];
    int n, freen;
    bit acc, exp_rec, exp_lost;
    check_head(tag);
    for (int i = 0; i < 4; i++) d[i] = PW'($urandom);
    {wp_valid, ot_valid, bt_valid, dt_valid} = v;
    wp_data = d[3]; ot_data = d[2]; bt_data = d[1]; dt_data = d[0];
    out_ready = r;
    if (v[3:1] != 0) begin
      for (int s = 3; s >= 1; s--) if (v[s] && picks.size() < 2) picks.push_back(s);
    end else if (v[0]) picks.push_back(0);
    n = picks.size();
    freen = DEPTH - mq.size();
    acc = 0;
    exp_rec = 0;
    if (m_drain) begin
      if (mq.size() == 0) begin
        exp_rec = 1;
        pushes.push_back({1'b1, 2'd0, PW'(m_mask | v)});
        m_drain = 0;
        m_mask = 0;
      end else m_mask = m_mask | v;
    end else if (n > freen) begin
      m_drain = 1;
      m_mask = 0;
      foreach (picks[k]) m_mask[picks[k]] = 1'b1;
    end else begin
      acc = 1;
      foreach (picks[k]) pushes.push_back({1'b0, 2'(picks[k]), d[picks[k]]});
    end
    exp_lost = v[0] && !(acc && n == 1 && picks[0] == 0);
    #1;
    check({tag, " R4 R5 dt_lost"}, 32'(dt_lost), 32'(exp_lost));
    check({tag, " R8 ovr_recovered"}, 32'(ovr_recovered), 32'(exp_rec));
    if (r && mq.size() != 0) void'(mq.pop_front());
    foreach (pushes[k]) mq.push_back(pushes[k]);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10: fill to exactly DEPTH with ready low, no overrun
    for (int i = 0; i < DEPTH; i++) step(4'b0010, 0, "R10 fill");
    check("R10 full no drain", 32'(m_drain), 32'd0);
    // overrun, then drain with offers (R6, R7)
    step(4'b0010, 0, "R6 trigger");
    step(4'b0100, 0, "R9 stall in drain");
    step(4'b0001, 1, "R6 drain");
    for (int i = 0; i < DEPTH + 2; i++) step(4'b0000, 1, "R7 drain out");
    // collisions with data trace, every pattern
    for (int p = 0; p < 16; p++) begin
      step(4'(p), 1, "R3 R4 pattern");
      step(4'b0000, 1, "R3 pattern out");
      step(4'b0000, 1, "R3 pattern out");
    end
    // mid-run reset while draining (R1)
    for (int i = 0; i < DEPTH; i++) step(4'b1100, 0, "R1 prefill");
    do_reset();
    step(4'b0000, 1, "R1 after reset");
    step(4'b0000, 1, "R1 after reset");
    // sweeps: all valid patterns against ready patterns
    for (int rp = 0; rp < 8; rp++) begin
      for (int rep = 0; rep < 6; rep++) begin
        for (int p = 0; p < 16; p++) begin
          bit r;
          case (rp)
            0: r = 1;
            1: r = 0;
            2: r = (p % 2) == 0;
            3: r = (p % 4) == 0;
            4: r = (p % 3) != 0;
            default: r = ($urandom % 8) < rp;
          endcase
          step(4'(p ^ rep), r, "R9 sweep");
        end
      end
      for (int i = 0; i < 2 * DEPTH + 2; i++) step(4'b0000, 1, "R7 sweep flush");
    end
    check_head("R2 final");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule